// File: doc/BRIEF.md
# Register-Indirect Jump Target Unit

This block works out where a register-indirect jump goes and whether it must trap instead. A request gives a base register value and a 12-bit immediate. The immediate is sign-extended and added to the base as a plain byte offset, with no scaling. The same request carries the jump's own PC and the destination register index, and the block returns the return-link value for that register.

Two inputs set how the low address bits are handled. The first is a strap that says whether compressed (16-bit) instructions are supported. The second is a mode select. In the default mode the least significant bit of the sum is dropped. In the alternative, nonstandard mode that bit is kept and a set bit is treated as a fault.

All decisions are made combinationally and registered once. The results of a request therefore appear on the cycle after it is presented. The target and the trap flag are both valid in that same cycle.

Top module: `jtu_top`

## Requirements
- R1: The effective address is `base_i` plus `imm_i` sign-extended to 64 bits, used as a byte offset and never shifted; the sum wraps modulo 2^64.
- R2: With `lsb_mode_i` = 0, the target is the effective address with bit 0 forced to 0. For example, base 0 or base 1 with immediate 0 both give target 0.
- R3: With `cmp_en_i` = 0, a target whose bit 1 is set raises `exc_o`, and `exc_addr_o` carries that target. For example, base 1 plus immediate 1 in mode 0 traps with address 2.
- R4: With `cmp_en_i` = 1 and `lsb_mode_i` = 0, a request never raises `exc_o`.
- R5: With `lsb_mode_i` = 1, bit 0 of the effective address is kept in the target. A set bit 0 raises `exc_o` whatever `cmp_en_i` is, and `exc_addr_o` is the unmodified effective address.
- R6: The results of a request taken at a clock edge appear after that edge. Exactly one of `tgt_vld_o` and `exc_o` is high, for one cycle.
- R7: On an exception, `tgt_o`, `link_o` and `link_rd_o` keep their previous values and `link_we_o` stays 0.
- R8: On a completed jump, `link_o` is the request's PC plus 4 (wrapping modulo 2^64) and `link_rd_o` is `rd_i`. `link_we_o` is 1 only when `rd_i` is not 0.
- R9: A cycle without a request leaves `tgt_vld_o`, `exc_o` and `link_we_o` at 0, and leaves `tgt_o` and `link_o` unchanged.
- R10: During reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Jump request, one cycle per jump |
| base_i | input | 64 | Base register value |
| imm_i | input | 12 | Signed immediate byte offset |
| pc_i | input | 64 | PC of the jump instruction |
| rd_i | input | 5 | Destination register index |
| cmp_en_i | input | 1 | 1 when compressed instructions are supported |
| lsb_mode_i | input | 1 | 0 clears bit 0; 1 keeps it and traps on it |
| tgt_vld_o | output | 1 | Target valid pulse |
| tgt_o | output | 64 | Fetch target |
| link_o | output | 64 | Return-link value |
| link_we_o | output | 1 | Link register write enable |
| link_rd_o | output | 5 | Link register index |
| exc_o | output | 1 | Misaligned-fetch exception pulse |
| exc_addr_o | output | 64 | Faulting address for the trap value |

## Verification
The hardest case to reach from the ports is a trap that must leave a non-zero earlier target untouched. That requires a successful jump to a distinct address, immediately followed by a faulting one. The stimulus sweeps every low-bit pattern of the base against odd, even, negative and extreme immediates, under all four combinations of strap and mode, so successes and traps interleave constantly. Bases near the top of the address space and a PC at the wrap point cover carry out of the adder.

// File: rtl/jtu_pkg.sv
package jtu_pkg;

    typedef enum logic {
        LSB_CLEAR = 1'b0,
        LSB_KEEP  = 1'b1
    } jtu_lsb_mode_e;

    typedef struct packed {
        logic bit0_fault;
        logic bit1_fault;
        logic trap;
    } jtu_align_t;

endpackage

// File: rtl/jtu_addr_calc.sv
module jtu_addr_calc #(
    parameter int XLEN  = 64,
    parameter int IMM_W = 12
) (
    input  logic [XLEN-1:0]       base_i,
    input  logic [IMM_W-1:0]      imm_i,
    input  jtu_pkg::jtu_lsb_mode_e mode_i,
    output logic [XLEN-1:0]       tgt_o
);
    localparam int EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] sum;

    always_comb begin
        imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
        sum     = base_i + imm_ext;
        tgt_o   = sum;
        if (mode_i == jtu_pkg::LSB_CLEAR) tgt_o[0] = 1'b0;
    end
endmodule

// File: rtl/jtu_align_check.sv
module jtu_align_check (
    input  logic [1:0]             low_i,
    input  logic                   cmp_en_i,
    input  jtu_pkg::jtu_lsb_mode_e mode_i,
    output jtu_pkg::jtu_align_t    chk_o
);
    always_comb begin
        chk_o.bit0_fault = (mode_i == jtu_pkg::LSB_KEEP) && low_i[0];
        chk_o.bit1_fault = !cmp_en_i && low_i[1];
        chk_o.trap       = chk_o.bit0_fault || chk_o.bit1_fault;
    end
endmodule

// File: rtl/jtu_link_gen.sv
module jtu_link_gen #(
    parameter int XLEN   = 64,
    parameter int REG_AW = 5,
    parameter int STEP   = 4
) (
    input  logic [XLEN-1:0]   pc_i,
    input  logic [REG_AW-1:0] rd_i,
    output logic [XLEN-1:0]   link_o,
    output logic              wr_ok_o
);
    always_comb begin
        link_o  = pc_i + XLEN'(STEP);
        wr_ok_o = (rd_i != '0);
    end
endmodule

// File: rtl/jtu_top.sv
module jtu_top #(
    parameter int XLEN         = 64,
    parameter int IMM_W        = 12,
    parameter int REG_AW       = 5,
    parameter int INSN_BYTES   = 4,
    parameter bit HAS_KEEP_MODE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [XLEN-1:0]   base_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [REG_AW-1:0] rd_i,
    input  logic              cmp_en_i,
    input  logic              lsb_mode_i,
    output logic              tgt_vld_o,
    output logic [XLEN-1:0]   tgt_o,
    output logic [XLEN-1:0]   link_o,
    output logic              link_we_o,
    output logic [REG_AW-1:0] link_rd_o,
    output logic              exc_o,
    output logic [XLEN-1:0]   exc_addr_o
);
    import jtu_pkg::*;

    typedef struct packed {
        logic              tgt_vld;
        logic [XLEN-1:0]   tgt;
        logic [XLEN-1:0]   link;
        logic              link_we;
        logic [REG_AW-1:0] link_rd;
        logic              exc;
        logic [XLEN-1:0]   exc_addr;
    } jtu_state_t;

    jtu_lsb_mode_e   mode_eff;
    logic [XLEN-1:0] tgt_c;
    logic [XLEN-1:0] link_c;
    logic            wr_ok_c;
    jtu_align_t      chk_c;
    jtu_state_t      st_d, st_q;

    generate
        if (HAS_KEEP_MODE) begin : g_mode
            assign mode_eff = jtu_lsb_mode_e'(lsb_mode_i);
        end else begin : g_fixed
            logic unused_mode;
            assign unused_mode = lsb_mode_i;
            assign mode_eff    = LSB_CLEAR;
        end
    endgenerate

    jtu_addr_calc #(.XLEN(XLEN), .IMM_W(IMM_W)) u_addr (
        .base_i (base_i),
        .imm_i  (imm_i),
        .mode_i (mode_eff),
        .tgt_o  (tgt_c)
    );

    jtu_align_check u_align (
        .low_i    (tgt_c[1:0]),
        .cmp_en_i (cmp_en_i),
        .mode_i   (mode_eff),
        .chk_o    (chk_c)
    );

    jtu_link_gen #(.XLEN(XLEN), .REG_AW(REG_AW), .STEP(INSN_BYTES)) u_link (
        .pc_i    (pc_i),
        .rd_i    (rd_i),
        .link_o  (link_c),
        .wr_ok_o (wr_ok_c)
    );

    always_comb begin
        st_d         = st_q;
        st_d.tgt_vld = 1'b0;
        st_d.exc     = 1'b0;
        st_d.link_we = 1'b0;
        if (req_i) begin
            if (chk_c.trap) begin
                st_d.exc      = 1'b1;
                st_d.exc_addr = tgt_c;
            end else begin
                st_d.tgt_vld = 1'b1;
                st_d.tgt     = tgt_c;
                st_d.link    = link_c;
                st_d.link_rd = rd_i;
                st_d.link_we = wr_ok_c;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tgt_vld_o  = st_q.tgt_vld;
    assign tgt_o      = st_q.tgt;
    assign link_o     = st_q.link;
    assign link_we_o  = st_q.link_we;
    assign link_rd_o  = st_q.link_rd;
    assign exc_o      = st_q.exc;
    assign exc_addr_o = st_q.exc_addr;

    // R6: result and trap are mutually exclusive
    p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(tgt_vld_o && exc_o));

    // R6: any outcome comes from a request one edge earlier
    p_outcome_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_vld_o || exc_o) |-> $past(req_i));

    // R9: no request, no pulses
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_i) |-> (!tgt_vld_o && !exc_o && !link_we_o));

    // R7: a trap leaves target and link untouched
    p_hold_on_exc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o |-> ($stable(tgt_o) && $stable(link_o) && !link_we_o));

    // R4: compressed support in clearing mode never traps
    p_no_trap_cmp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o |-> !($past(cmp_en_i) && !$past(lsb_mode_i)));

    // R2: clearing mode yields even targets
    p_even_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_vld_o && !$past(lsb_mode_i)) |-> !tgt_o[0]);

    // R8: register 0 is never written
    p_no_x0_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> (link_rd_o != '0));

    // R3: traps report an address with a bad low bit
    p_fault_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o |-> (exc_addr_o[1:0] != 2'b00));
endmodule

// File: tb/jtu_top_test.sv
module jtu_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_i;
    logic [63:0] base_i;
    logic [11:0] imm_i;
    logic [63:0] pc_i;
    logic [4:0]  rd_i;
    logic        cmp_en_i;
    logic        lsb_mode_i;
    logic        tgt_vld_o;
    logic [63:0] tgt_o;
    logic [63:0] link_o;
    logic        link_we_o;
    logic [4:0]  link_rd_o;
    logic        exc_o;
    logic [63:0] exc_addr_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [63:0] exp_tgt  = '0;
    logic [63:0] exp_link = '0;
    logic [4:0]  exp_rd   = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    jtu_top uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .base_i(base_i), .imm_i(imm_i),
        .pc_i(pc_i), .rd_i(rd_i), .cmp_en_i(cmp_en_i), .lsb_mode_i(lsb_mode_i),
        .tgt_vld_o(tgt_vld_o), .tgt_o(tgt_o), .link_o(link_o), .link_we_o(link_we_o),
        .link_rd_o(link_rd_o), .exc_o(exc_o), .exc_addr_o(exc_addr_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] pick_base(input int i);
        case (i)
            8:  return 64'hFFFF_FFFF_FFFF_FFFF;
            9:  return 64'hFFFF_FFFF_FFFF_FFFE;
            10: return 64'h0000_0000_0000_1002;
            11: return 64'h8000_0000_0000_0003;
            default: return 64'(i);
        endcase
    endfunction

    function automatic logic [11:0] pick_imm(input int i);
        case (i)
            0: return 12'd0;
            1: return 12'd1;
            2: return 12'd2;
            3: return 12'd3;
            4: return 12'hFFF;
            5: return 12'hFFE;
            6: return 12'h7FF;
            default: return 12'h800;
        endcase
    endfunction

    task automatic run_one(input logic [63:0] b, input logic [11:0] im, input bit c,
                           input bit m, input logic [63:0] pc, input logic [4:0] rd);
        logic [63:0] ea, t, lk;
        bit trap;
        ea = b + {{52{im[11]}}, im};
        t  = m ? ea : {ea[63:1], 1'b0};
        trap = (m && t[0]) || (!c && t[1]);
        lk = pc + 64'd4;
        @(negedge clk);
        req_i = 1'b1; base_i = b; imm_i = im; cmp_en_i = c; lsb_mode_i = m;
        pc_i = pc; rd_i = rd;
        @(negedge clk);
        req_i = 1'b0;
        chk(exc_o == trap, "R3/R4/R5 trap decision", 64'(exc_o), 64'(trap));
        chk(tgt_vld_o == !trap, "R6 target valid pulse", 64'(tgt_vld_o), 64'(!trap));
        if (trap) begin
            chk(exc_addr_o == t, "R3/R5 faulting address", exc_addr_o, t);
            chk(tgt_o == exp_tgt, "R7 target held on trap", tgt_o, exp_tgt);
            chk(link_o == exp_link && !link_we_o && link_rd_o == exp_rd,
                "R7 link held on trap", link_o, exp_link);
        end else begin
            exp_tgt = t; exp_link = lk; exp_rd = rd;
            chk(tgt_o == t, "R1/R2/R5 target value", tgt_o, t);
            chk(link_o == lk, "R8 link value", link_o, lk);
            chk(link_rd_o == rd, "R8 link index", 64'(link_rd_o), 64'(rd));
            chk(link_we_o == (rd != 0), "R8 link write enable", 64'(link_we_o), 64'(rd != 0));
        end
        // idle cycle with noise on the data inputs
        base_i = ~b; imm_i = ~im; pc_i = ~pc; rd_i = 5'd7;
        @(negedge clk);
        chk(!tgt_vld_o && !exc_o && !link_we_o, "R9 idle pulses", 64'({tgt_vld_o, exc_o, link_we_o}), 64'd0);
        chk(tgt_o == exp_tgt && link_o == exp_link, "R9 idle hold", tgt_o, exp_tgt);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_i = 1'b0; base_i = '0; imm_i = '0; pc_i = '0; rd_i = '0;
        cmp_en_i = 1'b0; lsb_mode_i = 1'b0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!tgt_vld_o && !exc_o && !link_we_o && tgt_o == 0 && link_o == 0 &&
            link_rd_o == 0 && exc_addr_o == 0, "R10 reset outputs", tgt_o, 64'd0);
        rst_n = 1'b1;

        // R2 corner: base 0 and base 1 with zero offset go to 0
        run_one(64'd5, 12'd0, 1'b0, 1'b0, 64'h100, 5'd1);
        run_one(64'd0, 12'd0, 1'b0, 1'b0, 64'h200, 5'd1);
        chk(tgt_o == 0, "R2 base0 off0", tgt_o, 0);
        run_one(64'd1, 12'd0, 1'b0, 1'b0, 64'h300, 5'd2);
        chk(tgt_o == 0, "R2 base1 off0", tgt_o, 0);
        // R3 corner: base 1 offset 1 traps at 2 after a nonzero target
        run_one(64'h40, 12'd0, 1'b0, 1'b0, 64'h400, 5'd3);
        run_one(64'd1, 12'd1, 1'b0, 1'b0, 64'h500, 5'd3);
        chk(exc_addr_o == 64'd2 && tgt_o == 64'h40, "R3 base1 off1 addr2", exc_addr_o, 64'd2);
        // R8 corner: PC wraps
        run_one(64'h80, 12'd0, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFC, 5'd0);

        for (int bi = 0; bi < 12; bi++)
            for (int ii = 0; ii < 8; ii++)
                for (int cm = 0; cm < 4; cm++)
                    run_one(pick_base(bi), pick_imm(ii), cm[0], cm[1],
                            64'h1000 + 64'(bi * 64 + ii * 8 + cm * 4),
                            5'((bi * 7 + ii * 3 + cm) % 32));

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule